// File: doc/BRIEF.md
# Status Register and Write-Protection Unit for a Serial Memory

This unit holds the status byte of a serial memory and rules on every write. The SPI front end decodes each command and passes it in as a one-cycle strobe: write enable, write disable with flag clear, flag set, status write with its data byte, and array write with its target address. The unit also takes the write-protect pin and a write-in-progress level from the self-timed write engine. It returns the assembled status byte for status reads. For each status write or array write it returns a one-cycle grant, or no grant when the write is refused.

The two-bit block field protects an upper part of the address space: a quarter, a half or all of it. A protect-enable bit, combined with the protect pin held low, locks the status register against further writes. Factory firmware can therefore set up the protection and then freeze it until the board pin changes. The protect-enable bit and the block field stand in for nonvolatile cells. They are ordinary registers and take their new value only when the write cycle that carries them finishes, which is when the write-in-progress level falls. Write enable and the flag are volatile and clear at reset.

Top module: `stat_lock_unit`

## Requirements
- R1: The status byte reads protect-enable at bit 7, flag at bit 6, constant 1 at bits 5 and 4, block field (high bit, low bit) at bits 3 and 2, write enable at bit 1, and the current write-in-progress input at bit 0 in the same cycle.
- R2: After reset, write enable and the flag are 0 and the nonvolatile bits take their initial value, all zero by default, so the idle status byte is 0x30.
- R3: A write-enable strobe sets bit 1. A write-disable strobe clears bit 1, and it wins when it arrives together with any source that would set the bit.
- R4: A flag-set strobe sets bit 6, and a write-disable strobe clears it.
- R5: While write enable is 0, status writes and array writes are never granted, and they change nothing.
- R6: With write enable set, an array write is refused when its 12-bit address lies in the protected range for the block field. Field 00 protects nothing, 01 protects 0xC00 to 0xFFF, 10 protects 0x800 to 0xFFF, and 11 protects every address.
- R7: With write enable set, protect-enable 1 and the synchronised protect pin low, a status write is refused, while an array write to an unprotected address is still granted.
- R8: With write enable set and either protect-enable 0 or the protect pin high, a status write is granted.
- R9: A granted status write takes only data bits 7, 6, 3 and 2. The new values appear in the status byte when the write-in-progress input next falls, and not before.
- R10: The protect pin is sampled when a status write is requested. If the pin falls during that write cycle, the write still completes, and later status writes are refused.
- R11: When the write cycle of a granted status write or array write ends, write enable is cleared.
- R12: A refused write leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| cmdWren | input | 1 | Write-enable command strobe |
| cmdWrdi | input | 1 | Write-disable and flag-clear command strobe |
| cmdFlagSet | input | 1 | Flag-set command strobe |
| cmdStatWr | input | 1 | Status write request strobe |
| statData | input | 8 | Data byte of the status write |
| cmdArrWr | input | 1 | Array write request strobe |
| arrAddr | input | ADDR_W (12) | Target address of the array write |
| wpPin | input | 1 | Write-protect pin, asynchronous |
| wipIn | input | 1 | Write-in-progress level from the write engine |
| statByte | output | 8 | Assembled status byte |
| statWrGrant | output | 1 | One-cycle pulse when a status write is granted |
| arrWrGrant | output | 1 | One-cycle pulse when an array write is granted |

## Verification
A table walks the protection decode for each block field value. It probes the first and last address of every range boundary, so an off-by-one in the range compare, or a field value mapped to the wrong range, shows up as a wrong grant. Directed sequences try the three lock cases: write enable cleared, protect-enable set with the pin low, and the pin high or protect-enable cleared. These tell apart a lock that also blocks array writes from one that lets status writes through. One sequence drops the protect pin in the middle of a status write cycle, which separates sampling at request time from sampling at commit time. Data bytes with bits 5:4 and 1:0 set, and with them cleared, show whether anything other than the four writable bits leaks into the register.

// File: rtl/stat_lock_pkg.sv
package stat_lock_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setFlag;
    logic clrFlag;
    logic loadPend;
    logic commit;
  } ctrlStrobe_t;

  // writable status fields
  typedef struct packed {
    logic       wpen;
    logic       flag;
    logic [1:0] blk;
  } statFields_t;
endpackage

// File: rtl/stat_lock_ctrl.sv
module stat_lock_ctrl
  import stat_lock_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdFlagSet,
  input  logic              cmdStatWr,
  input  logic              cmdArrWr,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic              wpPin,
  input  logic              wipIn,
  input  logic              welQ,
  input  logic              wpenQ,
  input  logic [1:0]        blkQ,
  output ctrlStrobe_t       strobe,
  output logic              statWrGrant,
  output logic              arrWrGrant
);
  localparam int TOP_HI = ADDR_W - 1;

  // protect pin synchroniser
  logic [SYNC_STAGES-1:0] wpSync;
  logic                   wpLevel;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) wpSync <= '0;
        else       wpSync <= wpPin;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) wpSync <= '0;
        else       wpSync <= {wpSync[SYNC_STAGES-2:0], wpPin};
    end
  endgenerate
  assign wpLevel = wpSync[SYNC_STAGES-1];

  // end of write cycle: falling edge of write-in-progress
  logic wipPrev;
  logic cycleEnd;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) wipPrev <= 1'b0;
    else       wipPrev <= wipIn;
  assign cycleEnd = wipPrev & ~wipIn;

  // block protection decode on the two top address bits
  logic [1:0] topBits;
  logic       inProt;
  assign topBits = arrAddr[TOP_HI -: 2];
  always_comb begin
    unique case (blkQ)
      2'b00:   inProt = 1'b0;
      2'b01:   inProt = &topBits;
      2'b10:   inProt = topBits[1];
      default: inProt = 1'b1;
    endcase
  end

  logic statLocked;
  logic statOk;
  logic arrOk;
  assign statLocked = wpenQ & ~wpLevel;
  assign statOk     = cmdStatWr & welQ & ~statLocked;
  assign arrOk      = cmdArrWr & welQ & ~inProt;

  // pending granted writes awaiting cycle end
  logic statPend;
  logic arrPend;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statPend <= 1'b0;
      arrPend  <= 1'b0;
    end else begin
      if (cycleEnd) begin
        statPend <= 1'b0;
        arrPend  <= 1'b0;
      end
      if (statOk) statPend <= 1'b1;
      if (arrOk)  arrPend  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statWrGrant <= 1'b0;
      arrWrGrant  <= 1'b0;
    end else begin
      statWrGrant <= statOk;
      arrWrGrant  <= arrOk;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.setWel   = cmdWren;
    strobe.clrWel   = cmdWrdi | (cycleEnd & (statPend | arrPend));
    strobe.setFlag  = cmdFlagSet;
    strobe.clrFlag  = cmdWrdi;
    strobe.loadPend = statOk;
    strobe.commit   = cycleEnd & statPend;
  end
endmodule

// File: rtl/stat_lock_dp.sv
module stat_lock_dp
  import stat_lock_pkg::*;
#(
  parameter logic [2:0] NV_INIT = 3'b000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [7:0]  statData,
  input  logic        wipIn,
  output logic        welQ,
  output logic        wpenQ,
  output logic [1:0]  blkQ,
  output logic [7:0]  statByte
);
  statFields_t cur;
  statFields_t pend;
  logic        wel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= '0;
    else if (strobe.loadPend)
      pend <= '{wpen: statData[7], flag: statData[6], blk: statData[3:2]};
  end

  // ordering gives the clear strobes the final word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur.wpen <= NV_INIT[2];
      cur.blk  <= NV_INIT[1:0];
      cur.flag <= 1'b0;
    end else begin
      if (strobe.commit) cur <= pend;
      if (strobe.setFlag) cur.flag <= 1'b1;
      if (strobe.clrFlag) cur.flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wel <= 1'b0;
    else begin
      if (strobe.setWel) wel <= 1'b1;
      if (strobe.clrWel) wel <= 1'b0;
    end
  end

  assign welQ     = wel;
  assign wpenQ    = cur.wpen;
  assign blkQ     = cur.blk;
  assign statByte = {cur.wpen, cur.flag, 2'b11, cur.blk, wel, wipIn};
endmodule

// File: rtl/stat_lock_unit.sv
module stat_lock_unit
  import stat_lock_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] NV_INIT     = 3'b000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdFlagSet,
  input  logic              cmdStatWr,
  input  logic [7:0]        statData,
  input  logic              cmdArrWr,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic              wpPin,
  input  logic              wipIn,
  output logic [7:0]        statByte,
  output logic              statWrGrant,
  output logic              arrWrGrant
);
  ctrlStrobe_t strobe;
  logic        welQ;
  logic        wpenQ;
  logic [1:0]  blkQ;

  stat_lock_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdFlagSet(cmdFlagSet),
    .cmdStatWr(cmdStatWr), .cmdArrWr(cmdArrWr), .arrAddr(arrAddr),
    .wpPin(wpPin), .wipIn(wipIn),
    .welQ(welQ), .wpenQ(wpenQ), .blkQ(blkQ),
    .strobe(strobe), .statWrGrant(statWrGrant), .arrWrGrant(arrWrGrant)
  );

  stat_lock_dp #(.NV_INIT(NV_INIT)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statData(statData),
    .wipIn(wipIn), .welQ(welQ), .wpenQ(wpenQ), .blkQ(blkQ),
    .statByte(statByte)
  );
endmodule

// File: rtl/stat_lock_chk.sv
module stat_lock_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWren,
  input logic              cmdWrdi,
  input logic              cmdStatWr,
  input logic              cmdArrWr,
  input logic [ADDR_W-1:0] arrAddr,
  input logic              wipIn,
  input logic [7:0]        statByte,
  input logic              statWrGrant,
  input logic              arrWrGrant
);
  assert_fixed_ones_R1: assert property (@(posedge clk) disable iff (!rstN)
    statByte[5:4] == 2'b11);

  assert_wip_mirror_R1: assert property (@(posedge clk) disable iff (!rstN)
    statByte[0] == wipIn);

  assert_wren_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWren && !cmdWrdi && wipIn |=> statByte[1]);

  assert_wrdi_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrdi |=> !statByte[1] && !statByte[6]);

  assert_stat_needs_wel_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdStatWr && !statByte[1] |=> !statWrGrant);

  assert_arr_needs_wel_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdArrWr && !statByte[1] |=> !arrWrGrant);

  assert_full_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdArrWr && statByte[3:2] == 2'b11 |=> !arrWrGrant);

  assert_nv_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wipIn |=> ##1 $stable({statByte[7], statByte[3:2]}));

  assert_grant_on_request_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmdStatWr |=> !statWrGrant);
endmodule

bind stat_lock_unit stat_lock_chk #(.ADDR_W(ADDR_W)) i_stat_lock_chk (
  .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi),
  .cmdStatWr(cmdStatWr), .cmdArrWr(cmdArrWr), .arrAddr(arrAddr),
  .wipIn(wipIn), .statByte(statByte), .statWrGrant(statWrGrant),
  .arrWrGrant(arrWrGrant)
);

// File: tb/test_stat_lock_unit.sv
module test_stat_lock_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWren = 1'b0, cmdWrdi = 1'b0, cmdFlagSet = 1'b0;
  logic        cmdStatWr = 1'b0, cmdArrWr = 1'b0;
  logic [7:0]  statData = '0;
  logic [11:0] arrAddr = '0;
  logic        wpPin = 1'b1;
  logic        wipIn = 1'b0;
  logic [7:0]  statByte;
  logic        statWrGrant, arrWrGrant;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stat_lock_unit i_stat_lock_unit (
    .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi),
    .cmdFlagSet(cmdFlagSet), .cmdStatWr(cmdStatWr), .statData(statData),
    .cmdArrWr(cmdArrWr), .arrAddr(arrAddr), .wpPin(wpPin), .wipIn(wipIn),
    .statByte(statByte), .statWrGrant(statWrGrant), .arrWrGrant(arrWrGrant)
  );

  // {block field, address, expected grant}
  localparam logic [14:0] VEC [10] = '{
    {2'd0, 12'hFFF, 1'b1}, {2'd0, 12'h000, 1'b1},
    {2'd1, 12'hBFF, 1'b1}, {2'd1, 12'hC00, 1'b0}, {2'd1, 12'hFFF, 1'b0},
    {2'd2, 12'h7FF, 1'b1}, {2'd2, 12'h800, 1'b0}, {2'd2, 12'hBFF, 1'b0},
    {2'd3, 12'h000, 1'b0}, {2'd3, 12'h7FF, 1'b0}
  };

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wait3(); repeat (3) tick(); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wren();  cmdWren = 1;    tick(); cmdWren = 0;    endtask
  task automatic wrdi();  cmdWrdi = 1;    tick(); cmdWrdi = 0;    endtask
  task automatic fset();  cmdFlagSet = 1; tick(); cmdFlagSet = 0; endtask
  task automatic statWrite(input logic [7:0] d);
    statData = d; cmdStatWr = 1; tick(); cmdStatWr = 0;
  endtask
  task automatic arrWrite(input logic [11:0] a);
    arrAddr = a; cmdArrWr = 1; tick(); cmdArrWr = 0;
  endtask
  task automatic endCycle();
    wipIn = 1; tick(); wipIn = 0; tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
  end

  initial begin
    logic [1:0] curBl;
    repeat (3) tick();
    rstN = 1;
    wait3();
    chk("R2 reset byte", statByte, 8'h30);

    statWrite(8'hFF);
    chk("R5 status no wel", {7'd0, statWrGrant}, 8'h00);
    chk("R5 state untouched", statByte, 8'h30);
    arrWrite(12'h000);
    chk("R5 array no wel", {7'd0, arrWrGrant}, 8'h00);

    wren();
    chk("R3 wren", statByte, 8'h32);
    fset();
    chk("R4 flag set", statByte, 8'h72);
    wrdi();
    chk("R3 R4 wrdi clears", statByte, 8'h30);
    wipIn = 1; #1;
    chk("R1 wip bit", statByte, 8'h31);
    wipIn = 0; tick();

    wren();
    statWrite(8'hFF);
    chk("R8 grant wp high", {7'd0, statWrGrant}, 8'h01);
    chk("R9 deferred", statByte, 8'h32);
    endCycle();
    chk("R9 R11 commit", statByte, 8'hFC);

    curBl = 2'd3;
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][14:13] != curBl) begin
        curBl = VEC[i][14:13];
        wren(); statWrite({4'd0, curBl, 2'd0}); endCycle();
      end
      wren();
      arrWrite(VEC[i][12:1]);
      chk($sformatf("R6 vec %0d", i), {7'd0, arrWrGrant}, {7'd0, VEC[i][0]});
    end

    wren(); statWrite(8'h80); endCycle();
    chk("R9 set wpen", statByte, 8'hB0);
    wpPin = 0; wait3();
    wren();
    statWrite(8'h0C);
    chk("R7 status locked", {7'd0, statWrGrant}, 8'h00);
    arrWrite(12'h100);
    chk("R7 array open", {7'd0, arrWrGrant}, 8'h01);
    chk("R12 refused no change", statByte, 8'hB2);
    endCycle();
    chk("R11 array end clears wel", statByte, 8'hB0);

    wpPin = 1; wait3();
    wren();
    statWrite(8'h88);
    chk("R8 grant pin high", {7'd0, statWrGrant}, 8'h01);
    wipIn = 1; tick();
    wpPin = 0; repeat (4) tick();
    wipIn = 0; tick();
    chk("R10 completes", statByte, 8'hB8);
    wren();
    statWrite(8'h00);
    chk("R10 later refused", {7'd0, statWrGrant}, 8'h00);
    chk("R12 still same", statByte, 8'hBA);

    wpPin = 1; wait3();
    statWrite(8'h00);
    chk("R8 unlock", {7'd0, statWrGrant}, 8'h01);
    endCycle();
    chk("R9 fixed bits", statByte, 8'h30);
    wpPin = 0; wait3();
    wren();
    statWrite(8'h47);
    chk("R8 wpen off pin low", {7'd0, statWrGrant}, 8'h01);
    endCycle();
    chk("R9 only four bits", statByte, 8'h74);
    wrdi();
    chk("R4 wrdi flag", statByte, 8'h34);

    summary();
  end
endmodule